// File: doc/BRIEF.md
# Serial-Addressed Octal Trim Code Bank

This block is the digital core of an eight-channel trim converter. A host writes one channel at a time over a three-wire serial link: an active-low select, a serial clock and a serial data line. While select is low, each rising serial-clock edge pushes one bit into an 11-bit shift register. When select returns high, the register is read as a 3-bit channel address followed by an 8-bit code, and that code lands in the one addressed channel register.

All eight codes are always visible on a flat output vector, together with an output-enable flag. A downstream ladder or driver turns these into voltages. An active-low preset forces every channel to the midscale code without waiting for a clock. An active-low shutdown drops the output-enable flag while every stored code is kept.

The three serial pins are brought into the system clock domain through two-flop synchronizers, and their edges are found after synchronization. For this reason the serial clock must toggle slower than half the system clock rate.

Top module: `trim_code_bank`

## Requirements
- R1: A frame is sent most significant bit first: 3 address bits, then 8 code bits. The code bits become the channel's output code unchanged.
- R2: While select is high, serial-clock edges leave the shift register untouched.
- R3: When more than 11 bits are clocked in before select rises, only the last 11 are used and the earlier ones are dropped.
- R4: Address value k writes channel k+1. In the port vector this is the slot `chan_code[k*8 +: 8]`, so address 0 is the lowest byte and address 7 is the highest byte.
- R5: Each rise of select updates exactly one channel and leaves the other seven unchanged. Channels may be written in any order.
- R6: Driving `preset_n` low sets every channel to 0x80 at once, without a clock edge. A select rise that arrives while preset is low does not write anything.
- R7: While `sleep_n` is low, `out_en` is 0 and the stored codes stay on `chan_code`. Once `sleep_n` returns high, `out_en` goes back to 1 and the codes are the same as before.
- R8: A frame received during shutdown is still written into its channel.
- R9: A frame shorter than 11 bits commits the current shift-register contents. The shift register is all zeros after reset, so a 3-bit frame `101` sent after reset writes 0x05 to channel address 0.
- R10: After reset every channel holds 0x80, and `out_en` follows `sleep_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| preset_n | input | 1 | Asynchronous active-low preset of all channels to midscale |
| sleep_n | input | 1 | Active-low shutdown |
| chan_code | output | 64 | Eight 8-bit channel codes; address k occupies bits k*8+7..k*8 |
| out_en | output | 1 | Output enable; low during shutdown |

## Verification
The hardest state to reach from the ports is the hidden shift register. Nothing in the block exposes it until a commit happens. To prove that clock edges with select high are ignored, and that short frames reuse leftover bits, the bench first resets the block so the register is known to be zero. It then either toggles the serial clock 11 times with data held high and select high, or sends a 3-bit frame. After that it raises select, so the register contents show up in the channel that gets written. Preset priority is checked by holding preset low across a complete frame, including the rising edge of select, and then confirming that the addressed channel still holds midscale.

// File: rtl/trim_bank_pkg.sv
package trim_bank_pkg;
  // Midscale code for a given code width: only the top bit set.
  function automatic logic [31:0] midscale(input int unsigned width);
    return 32'(1) << (width - 1);
  endfunction
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_nxt;

  always_comb begin
    stage_nxt[0] = d;
    for (int i = 1; i < STAGES; i++) stage_nxt[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_nxt;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/trim_frame_rx.sv
module trim_frame_rx #(
  parameter int unsigned FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_s,
  input  logic               sclk_s,
  input  logic               sdata_s,
  output logic               commit,
  output logic [FRAME_W-1:0] frame_bits
);
  logic               sclk_d, sel_d;
  logic [FRAME_W-1:0] shreg_q, shreg_nxt;
  logic               sclk_rise, shift_en;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign shift_en  = sclk_rise & ~sel_s;
  assign commit    = sel_s & ~sel_d;

  always_comb begin
    shreg_nxt = shreg_q;
    if (shift_en) shreg_nxt = {shreg_q[FRAME_W-2:0], sdata_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      sclk_d  <= 1'b0;
      sel_d   <= 1'b1;
    end else begin
      shreg_q <= shreg_nxt;
      sclk_d  <= sclk_s;
      sel_d   <= sel_s;
    end
  end

  assign frame_bits = shreg_q;
endmodule

// File: rtl/trim_code_store.sv
module trim_code_store
  import trim_bank_pkg::*;
#(
  parameter int unsigned CH_N   = 8,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned ADDR_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     preset_n,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_data,
  output logic [CH_N*CODE_W-1:0]   codes
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] code_q, code_nxt;

    assign hit = wr_stb && (wr_addr == ADDR_W'(i));

    always_comb begin
      code_nxt = code_q;
      if (hit) code_nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n or negedge preset_n) begin
      if (!rst_n)         code_q <= MID;
      else if (!preset_n) code_q <= MID;
      else                code_q <= code_nxt;
    end

    assign codes[i*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/trim_code_bank.sv
module trim_code_bank #(
  parameter int unsigned CH_N        = 8,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W  = (CH_N > 1) ? $clog2(CH_N) : 1,
  localparam int unsigned FRAME_W = ADDR_W + CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_n,
  input  logic                   sclk,
  input  logic                   sdata,
  input  logic                   preset_n,
  input  logic                   sleep_n,
  output logic [CH_N*CODE_W-1:0] chan_code,
  output logic                   out_en
);
  logic [2:0]         pins_s;
  logic               sel_sync, sclk_sync, sdata_sync;
  logic               commit;
  logic [FRAME_W-1:0] frame_bits;

  trim_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, sclk, sdata}), .q(pins_s)
  );
  assign {sel_sync, sclk_sync, sdata_sync} = pins_s;

  trim_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_sync), .sclk_s(sclk_sync),
    .sdata_s(sdata_sync), .commit(commit), .frame_bits(frame_bits)
  );

  trim_code_store #(.CH_N(CH_N), .CODE_W(CODE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .wr_stb(commit),
    .wr_addr(frame_bits[FRAME_W-1 -: ADDR_W]), .wr_data(frame_bits[CODE_W-1:0]),
    .codes(chan_code)
  );

  assign out_en = sleep_n;
endmodule

// File: rtl/trim_code_bank_chk.sv
module trim_code_bank_chk #(
  parameter int unsigned CH_N    = 8,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned FRAME_W = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   preset_n,
  input logic                   sel_s,
  input logic [FRAME_W-1:0]     shreg,
  input logic                   wr_stb,
  input logic [CH_N*CODE_W-1:0] chan_code
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CH_N*CODE_W-1:0] prev_code;
  int unsigned            n_changed;
  logic                   all_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_code <= {CH_N{MID}};
    else        prev_code <= chan_code;
  end

  always_comb begin
    n_changed = 0;
    all_mid   = 1'b1;
    for (int i = 0; i < CH_N; i++) begin
      if (chan_code[i*CODE_W +: CODE_W] != prev_code[i*CODE_W +: CODE_W]) n_changed++;
      if (chan_code[i*CODE_W +: CODE_W] != MID) all_mid = 1'b0;
    end
  end

  // R2: select high freezes the shift register
  assert_sel_high_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> $stable(shreg));

  // R5: at most one channel changes per clock outside preset
  assert_one_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_n && $past(preset_n)) |-> (n_changed <= 1));

  // R5: codes only move on a commit
  assert_no_write_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && preset_n) |=> (!preset_n || $stable(chan_code)));

  // R6: preset low means every channel at midscale
  assert_preset_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |-> all_mid);
endmodule

bind trim_code_bank trim_code_bank_chk #(.CH_N(CH_N), .CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .sel_s(sel_sync),
  .shreg(frame_bits), .wr_stb(commit), .chan_code(chan_code)
);

// File: tb/trim_code_bank_tb.sv
module trim_code_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n, sel_n, sclk, sdata, preset_n, sleep_n;
  logic [63:0] chan_code;
  logic        out_en;
  int          n_checks = 0;
  int          n_fail = 0;
  logic [7:0]  shadow [8];

  trim_code_bank u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .preset_n(preset_n), .sleep_n(sleep_n), .chan_code(chan_code), .out_en(out_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) check(req, 32'(chan_code[i*8 +: 8]), 32'(shadow[i]));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdata = 1'b0;
    preset_n = 1'b1; sleep_n = 1'b1;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(2);
    for (int i = 0; i < 8; i++) shadow[i] = 8'h80;
  endtask

  task automatic clock_bit(input logic b);
    sdata = b; sclk = 1'b0; wait_clks(HOLD);
    sclk = 1'b1; wait_clks(HOLD);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    sel_n = 1'b0; wait_clks(HOLD);
    for (int i = n - 1; i >= 0; i--) clock_bit(bits[i]);
    wait_clks(HOLD);
    sel_n = 1'b1; wait_clks(6);
  endtask

  task automatic write_ch(input int addr, input logic [7:0] val);
    send_bits({21'd0, 3'(addr), val}, 11);
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R10 reset code");
    check("R10 out_en after reset", 32'(out_en), 32'd1);
  endtask

  task automatic t_basic();
    write_ch(2, 8'hA5); shadow[2] = 8'hA5;
    check("R1 R4 code in slot 2", 32'(chan_code[16 +: 8]), 32'hA5);
    check_all("R5 others untouched");
  endtask

  task automatic t_any_order();
    int order [8] = '{7, 0, 5, 1, 6, 2, 4, 3};
    for (int k = 0; k < 8; k++) begin
      logic [7:0] v = 8'(8'h13 * (order[k] + 1) ^ 8'h5A);
      write_ch(order[k], v); shadow[order[k]] = v;
    end
    check_all("R4 R5 eight frames any order");
  endtask

  task automatic t_sel_high();
    do_reset();
    for (int i = 0; i < 11; i++) clock_bit(1'b1);
    wait_clks(4);
    send_bits(32'd0, 0);
    shadow[0] = 8'h00;
    check("R2 select high ignored slot 7", 32'(chan_code[56 +: 8]), 32'h80);
    check("R2 R9 empty frame commits zero", 32'(chan_code[0 +: 8]), 32'h00);
  endtask

  task automatic t_long();
    send_bits({5'b11111, 3'd6, 8'h3C}, 16); shadow[6] = 8'h3C;
    check("R3 long frame last 11 bits", 32'(chan_code[48 +: 8]), 32'h3C);
    check_all("R3 long frame others");
  endtask

  task automatic t_short();
    do_reset();
    send_bits(32'b101, 3); shadow[0] = 8'h05;
    check("R9 short frame", 32'(chan_code[0 +: 8]), 32'h05);
    check_all("R9 short frame others");
  endtask

  task automatic t_preset();
    write_ch(3, 8'h12); shadow[3] = 8'h12;
    write_ch(7, 8'hFE); shadow[7] = 8'hFE;
    preset_n = 1'b0;
    #2;
    for (int i = 0; i < 8; i++) shadow[i] = 8'h80;
    check_all("R6 async preset");
    wait_clks(2);
    preset_n = 1'b1; wait_clks(2);
    check_all("R6 after preset release");
  endtask

  task automatic t_preset_priority();
    preset_n = 1'b0;
    write_ch(1, 8'h77);
    wait_clks(2);
    preset_n = 1'b1; wait_clks(3);
    check("R6 preset beats commit", 32'(chan_code[8 +: 8]), 32'h80);
  endtask

  task automatic t_sleep();
    write_ch(4, 8'h9E); shadow[4] = 8'h9E;
    sleep_n = 1'b0; wait_clks(1);
    check("R7 out_en low in shutdown", 32'(out_en), 32'd0);
    check("R7 code kept in shutdown", 32'(chan_code[32 +: 8]), 32'h9E);
    write_ch(5, 8'h42); shadow[5] = 8'h42;
    check("R8 frame during shutdown", 32'(chan_code[40 +: 8]), 32'h42);
    sleep_n = 1'b1; wait_clks(1);
    check("R7 out_en restored", 32'(out_en), 32'd1);
    check_all("R7 codes restored");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_any_order();
    t_long();
    t_sel_high();
    t_short();
    t_preset();
    t_preset_priority();
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule